// File: doc/BRIEF.md
# Masked Input-Change Interrupt Unit

This block watches a word of switch inputs and raises an interrupt request while any of them differs from a snapshot held in a status register. A mask register decides which positions may raise the request. The request is not latched. It is a live comparison, so it drops by itself when the inputs go back to the snapshot, or when a new snapshot is captured. The output is a drive-low enable for an active-low open-drain line. Several units can therefore share one pulled-up wire as a wired-AND.

An enable input has two jobs. It releases the interrupt line, and it freezes the block's view of the inputs while switch biasing is cycled off. While the enable is low, the block keeps the last state it saw. A capture taken then returns that held state and not the live pins. When the same input level comes back after re-biasing, it matches the snapshot and no false request follows.

The inputs pass through a two-stage synchronizer before the held-view register. The serial transfer that reads the snapshot and supplies the mask is outside this block. That transfer drives the capture strobe and the mask write. Writing a mask of all zeros acts as a software reset.

Top module: `chg_irq_unit`

## Requirements
- R1: After synchronous reset, the status output is all zeros, the mask is all zeros and the interrupt drive is 0 (line released).
- R2: With enable high and no capture or mask write in the cycle, the interrupt drive becomes 1 at the clock edge after the held view differs from the status register in a position whose mask bit is 1. A pin change reaches the held view on the third rising edge after it is applied, so the drive rises on the fourth.
- R3: A mask bit of 0 stops its position from ever setting the interrupt drive. Because the mask resets to zero, no request is possible until a nonzero mask is written.
- R4: A capture strobe loads the status register from the held view at that edge (visible on the status output) and forces the interrupt drive to 0 at the same edge.
- R5: When the inputs return to the captured values, the interrupt drive falls to 0 without any capture.
- R6: While enable is low, the interrupt drive is 0 from the next clock edge on.
- R7: While enable is low, the held view keeps the value it had when enable fell, and a capture in that period stores that held value, whatever the live pins are.
- R8: A mask write whose value is all zeros is a software reset. At that edge the status register and the mask clear to zero and the interrupt drive goes to 0. This takes priority over a capture in the same cycle.
- R9: A mask write with a nonzero value replaces the whole mask at that edge. A bit is enabled when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | W (16) | Asynchronous switch input levels |
| en_i | input | 1 | Enable for the input view and the interrupt output |
| cap_i | input | 1 | One-cycle strobe: snapshot the held view into the status register |
| mask_wr_i | input | 1 | One-cycle strobe: load the mask (all zeros means software reset) |
| mask_i | input | W (16) | Mask value. A 1 enables its position |
| status_o | output | W (16) | Status register contents |
| irq_drive_o | output | 1 | 1 pulls the shared active-low interrupt line low, 0 releases it |

## Verification
Changes are applied in masked and unmasked positions, so that a request caused by the mask can be told apart from a request caused by the comparison. A single unmasked bit is toggled and then restored, to measure the four-edge latency and to confirm that the request clears without a capture. New pin values are applied while the enable is low and then captured, which separates the frozen view from the live pins. A zero mask write after an active request shows the software reset clearing the status output, as distinct from an ordinary capture.

// File: rtl/cii_pkg.sv
package cii_pkg;
  localparam int unsigned DEF_W    = 16;
  localparam int unsigned DEF_SYNC = 2;

  typedef struct packed {
    logic capture;
    logic soft_rst;
    logic mask_wr;
  } cii_cmd_t;
endpackage

// File: rtl/cii_sync.sv
module cii_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '0;
        else     stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cii_hold.sv
module cii_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/cii_regs.sv
module cii_regs
  import cii_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  cii_cmd_t     cmd,
  input  logic [W-1:0] mask_in,
  input  logic [W-1:0] view,
  output logic [W-1:0] status_q,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst || cmd.soft_rst) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      if (cmd.capture) status_q <= view;
      if (cmd.mask_wr) mask_q   <= mask_in;
    end
  end
endmodule

// File: rtl/cii_irq.sv
module cii_irq #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         block,
  input  logic [W-1:0] view,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  output logic         drive
);
  logic [W-1:0] live_diff;
  logic         any_diff;

  always_comb begin
    live_diff = (view ^ status) & mask;
    any_diff  = |live_diff;
  end

  always_ff @(posedge clk) begin
    if (rst) drive <= 1'b0;
    else     drive <= en & ~block & any_diff;
  end
endmodule

// File: rtl/chg_irq_unit.sv
module chg_irq_unit
  import cii_pkg::*;
#(
  parameter int unsigned W    = DEF_W,
  parameter int unsigned SYNC = DEF_SYNC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_i,
  input  logic         en_i,
  input  logic         cap_i,
  input  logic         mask_wr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] status_o,
  output logic         irq_drive_o
);
  logic [W-1:0] pins_s;
  logic [W-1:0] view_q;
  logic [W-1:0] mask_q;
  cii_cmd_t     cmd;

  always_comb begin
    cmd.capture  = cap_i;
    cmd.mask_wr  = mask_wr_i;
    cmd.soft_rst = mask_wr_i && (mask_i == '0);
  end

  cii_sync #(.W(W), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .d(pins_i), .q(pins_s)
  );

  cii_hold #(.W(W)) u_hold (
    .clk(clk), .rst(rst), .en(en_i), .d(pins_s), .q(view_q)
  );

  cii_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .cmd(cmd), .mask_in(mask_i), .view(view_q),
    .status_q(status_o), .mask_q(mask_q)
  );

  cii_irq #(.W(W)) u_irq (
    .clk(clk), .rst(rst), .en(en_i), .block(cmd.capture | cmd.soft_rst),
    .view(view_q), .status(status_o), .mask(mask_q), .drive(irq_drive_o)
  );
endmodule

// File: rtl/chg_irq_unit_chk.sv
module chg_irq_unit_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         en_i,
  input logic         cap_i,
  input logic         mask_wr_i,
  input logic [W-1:0] mask_i,
  input logic [W-1:0] view_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] status_o,
  input logic         irq_drive_o
);
  // R6
  en_off_release_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !irq_drive_o);

  // R4
  cap_clears_chk: assert property (@(posedge clk) disable iff (rst)
    cap_i |=> !irq_drive_o);

  // R4
  cap_loads_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_i && !(mask_wr_i && mask_i == '0)) |=> status_o == $past(view_q));

  // R8
  soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_wr_i && mask_i == '0) |=> (status_o == '0 && mask_q == '0 && !irq_drive_o));

  // R7
  view_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(view_q));

  // R3
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_drive_o |-> $past(mask_q) != '0);

  // R2
  raise_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !cap_i && !mask_wr_i && ((view_q ^ status_o) & mask_q) != '0) |=> irq_drive_o);

  // R9
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_wr_i && mask_i != '0) |=> mask_q == $past(mask_i));
endmodule

bind chg_irq_unit chg_irq_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .cap_i(cap_i), .mask_wr_i(mask_wr_i),
  .mask_i(mask_i), .view_q(view_q), .mask_q(mask_q), .status_o(status_o),
  .irq_drive_o(irq_drive_o)
);

// File: tb/chg_irq_unit_test.sv
module chg_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pins = '0;
  logic        en = 1'b0;
  logic        cap = 1'b0;
  logic        mask_wr = 1'b0;
  logic [15:0] mask_in = '0;
  logic [15:0] status;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chg_irq_unit uut (
    .clk(clk), .rst(rst), .pins_i(pins), .en_i(en), .cap_i(cap),
    .mask_wr_i(mask_wr), .mask_i(mask_in), .status_o(status), .irq_drive_o(irq)
  );

  // Behavioural reference
  logic [15:0] pq[$];
  logic [15:0] mv, ms, mm, s2;
  logic        mi, swr;

  always @(posedge clk) begin
    if (rst) begin
      pq.delete();
      mv = '0; ms = '0; mm = '0; mi = 1'b0;
    end else begin
      s2  = (pq.size() == 2) ? pq[0] : 16'h0;
      swr = mask_wr && (mask_in == 16'h0);
      mi  = en && !cap && !swr && (((mv ^ ms) & mm) != 16'h0);
      if (swr) begin
        ms = '0; mm = '0;
      end else begin
        if (cap)     ms = mv;
        if (mask_wr) mm = mask_in;
      end
      if (en) mv = s2;
      pq.push_back(pins);
      if (pq.size() > 2) void'(pq.pop_front());
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 model irq", {15'h0, irq}, {15'h0, mi});
      chk("R4 model status", status, ms);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cap();
    cap = 1'b1; step(1); cap = 1'b0;
  endtask

  task automatic write_mask(logic [15:0] v);
    mask_in = v; mask_wr = 1'b1; step(1); mask_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 status", status, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);

    en = 1'b1; pins = 16'h00F0;
    step(6);
    chk("R3 zero mask after reset", {15'h0, irq}, 16'h0);

    write_mask(16'h00FF);          // R9
    step(1);
    chk("R2 unmasked diff", {15'h0, irq}, 16'h1);

    pulse_cap();
    chk("R4 capture status", status, 16'h00F0);
    chk("R4 capture clears", {15'h0, irq}, 16'h0);
    step(2);
    chk("R4 stays clear", {15'h0, irq}, 16'h0);

    pins = 16'h10F0;
    step(6);
    chk("R3 masked change", {15'h0, irq}, 16'h0);

    pins = 16'h10F1;
    step(3);
    chk("R2 latency before", {15'h0, irq}, 16'h0);
    step(1);
    chk("R2 latency edge 4", {15'h0, irq}, 16'h1);

    pins = 16'h10F0;
    step(4);
    chk("R5 return clears", {15'h0, irq}, 16'h0);

    pins = 16'h10F3;
    step(4);
    chk("R2 second raise", {15'h0, irq}, 16'h1);
    en = 1'b0;
    step(1);
    chk("R6 enable low release", {15'h0, irq}, 16'h0);

    pins = 16'hABCD;
    step(5);
    pulse_cap();
    chk("R7 frozen capture", status, 16'h10F3);
    chk("R6 still released", {15'h0, irq}, 16'h0);

    en = 1'b1;
    step(4);
    chk("R2 after re-enable", {15'h0, irq}, 16'h1);

    cap = 1'b1; mask_in = 16'h0; mask_wr = 1'b1;
    step(1);
    cap = 1'b0; mask_wr = 1'b0;
    chk("R8 soft reset status", status, 16'h0);
    chk("R8 soft reset irq", {15'h0, irq}, 16'h0);
    step(5);
    chk("R8 mask cleared", {15'h0, irq}, 16'h0);

    write_mask(16'h0001);          // R9: only bit 0 enabled, view bit 0 is 1
    step(1);
    chk("R9 new mask active", {15'h0, irq}, 16'h1);

    step(2);
    finish_run();
  end
endmodule